// File: doc/BRIEF.md
# Fail-Safe Configuration Image Selector

This block steers one address line of a configuration memory that holds two images: an updated image that may be corrupt and a known-good fallback image. Each load of the device configuration opens with a start strobe and closes with a result strobe, which the loader raises after it has checked the CRC at the end of the image. Until the first failed load the address line is left undriven, so a board pull-up decides which half of the memory is read first. After that failure the block drives the line low. Each later failure inverts it, so successive retries read the two halves in turn.

A passing load locks the line at its current level and raises a done flag. From then on the block ignores all strobes until reset. Reset clears both the drive enable and the level, which returns the line to its undriven state. A saturating count of the failed loads is available for observation.

The controller is a five-state machine:
- `ST_CLEAN_WAIT`: no failure yet, no load open.
- `ST_CLEAN_LOAD`: no failure yet, load open.
- `ST_ALT_WAIT`: at least one failure, line driven, no load open.
- `ST_ALT_LOAD`: at least one failure, load open.
- `ST_LOCKED`: a load passed.

The transitions are:
- open: a `WAIT` state goes to its `LOAD` state on `load_start_i`.
- first-fail: `ST_CLEAN_LOAD` goes to `ST_ALT_WAIT` on a fail.
- retry-fail: `ST_ALT_LOAD` goes to `ST_ALT_WAIT` on a fail.
- pass: either `LOAD` state goes to `ST_LOCKED` on a pass.
- reset: any state returns to `ST_CLEAN_WAIT`.

Top module: `cfg_image_toggle`

## Requirements
- R1: While reset (`rst_ni` low, asynchronous) is asserted, and in the first cycle after it is released, `img_sel_oe_o`=0, `img_sel_o`=0, `cfg_done_o`=0 and `fail_count_o`=0.
- R2: While no failed load has been accepted, `img_sel_oe_o` stays 0 (line undriven) and `img_sel_o` stays 0.
- R3: When a fail (`crc_fail_i`=1, `crc_pass_i`=0) is sampled during an open load and no failure has been accepted before, the next clock edge sets `img_sel_oe_o`=1 and `img_sel_o`=0.
- R4: Each later fail sampled during an open load inverts `img_sel_o` at the next clock edge, with `img_sel_oe_o` remaining 1.
- R5: A pass (`crc_pass_i`=1) sampled during an open load sets `cfg_done_o`=1 at the next edge and leaves `img_sel_o` and `img_sel_oe_o` at their previous values.
- R6: Once `cfg_done_o`=1, all strobes are ignored: `img_sel_o`, `img_sel_oe_o`, `fail_count_o` and `cfg_done_o` hold until reset.
- R7: A pass and a fail sampled in the same cycle of an open load are treated as a pass: the count does not change and the line does not toggle.
- R8: A load is open from the edge after `load_start_i` is sampled until a result is accepted. Result strobes outside an open load, and `load_start_i` during an open load, have no effect.
- R9: `fail_count_o` (CNT_W bits) increments by one per accepted fail and saturates at 2^CNT_W-1 without wrapping.
- R10: Asserting reset at any point, including after lock, returns all outputs to the R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_start_i | input | 1 | Strobe that opens a configuration load attempt |
| crc_pass_i | input | 1 | Result strobe: the image CRC matched |
| crc_fail_i | input | 1 | Result strobe: the image CRC did not match |
| img_sel_o | output | 1 | Level for the configuration-memory address line |
| img_sel_oe_o | output | 1 | Drive enable for the address line (0 = undriven) |
| cfg_done_o | output | 1 | A load has passed; the selection is frozen |
| fail_count_o | output | CNT_W | Saturating count of accepted failed loads |

## Verification
Two functions can fall in the same cycle: the pass path, which locks the block, and the fail path, which toggles the line and counts. The bench provokes this by raising both result strobes together during an open load after several failures. It then checks that the done flag rises while both the count and the line level hold. It also lands a start strobe on the same cycle as a result strobe, and strobes results while no load is open. A scoreboard model judges the outputs cycle by cycle.

// File: rtl/cfgtog_pkg.sv
package cfgtog_pkg;

    typedef enum logic [2:0] {
        ST_CLEAN_WAIT = 3'd0,
        ST_CLEAN_LOAD = 3'd1,
        ST_ALT_WAIT   = 3'd2,
        ST_ALT_LOAD   = 3'd3,
        ST_LOCKED     = 3'd4
    } sel_state_e;

    typedef struct packed {
        logic take_fail;
        logic first_fail;
        logic take_pass;
    } sel_event_t;

endpackage

// File: rtl/cfgtog_fsm.sv
module cfgtog_fsm
    import cfgtog_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       load_start_i,
    input  logic       crc_pass_i,
    input  logic       crc_fail_i,
    output sel_event_t evt_o,
    output logic       locked_o
);

    sel_state_e state_q, state_d;
    logic       pass_seen, fail_seen;

    // A pass outranks a fail in the same cycle (R7)
    assign pass_seen = crc_pass_i;
    assign fail_seen = crc_fail_i & ~crc_pass_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_CLEAN_WAIT;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d          = state_q;
        evt_o.take_fail  = 1'b0;
        evt_o.first_fail = 1'b0;
        evt_o.take_pass  = 1'b0;
        unique case (state_q)
            ST_CLEAN_WAIT: begin
                if (load_start_i) state_d = ST_CLEAN_LOAD;
            end
            ST_CLEAN_LOAD: begin
                if (pass_seen) begin
                    state_d         = ST_LOCKED;
                    evt_o.take_pass = 1'b1;
                end else if (fail_seen) begin
                    state_d          = ST_ALT_WAIT;
                    evt_o.take_fail  = 1'b1;
                    evt_o.first_fail = 1'b1;
                end
            end
            ST_ALT_WAIT: begin
                if (load_start_i) state_d = ST_ALT_LOAD;
            end
            ST_ALT_LOAD: begin
                if (pass_seen) begin
                    state_d         = ST_LOCKED;
                    evt_o.take_pass = 1'b1;
                end else if (fail_seen) begin
                    state_d         = ST_ALT_WAIT;
                    evt_o.take_fail = 1'b1;
                end
            end
            ST_LOCKED: begin
                state_d = ST_LOCKED;
            end
            default: begin
                state_d = ST_CLEAN_WAIT;
            end
        endcase
    end

    assign locked_o = (state_q == ST_LOCKED);

endmodule

// File: rtl/cfgtog_pin.sv
module cfgtog_pin
    import cfgtog_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  sel_event_t evt_i,
    output logic       level_o,
    output logic       oe_o
);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            oe_o    <= 1'b0;
            level_o <= 1'b0;
        end else if (evt_i.take_fail) begin
            if (evt_i.first_fail) begin
                oe_o    <= 1'b1;
                level_o <= 1'b0;
            end else begin
                level_o <= ~level_o;
            end
        end
    end

endmodule

// File: rtl/cfgtog_satcnt.sv
module cfgtog_satcnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          count_o <= '0;
        else if (inc_i && count_o != CNT_MAX) count_o <= count_o + 1'b1;
    end

endmodule

// File: rtl/cfg_image_toggle.sv
module cfg_image_toggle
    import cfgtog_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_start_i,
    input  logic             crc_pass_i,
    input  logic             crc_fail_i,
    output logic             img_sel_o,
    output logic             img_sel_oe_o,
    output logic             cfg_done_o,
    output logic [CNT_W-1:0] fail_count_o
);

    sel_event_t evt;

    cfgtog_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .load_start_i (load_start_i),
        .crc_pass_i   (crc_pass_i),
        .crc_fail_i   (crc_fail_i),
        .evt_o        (evt),
        .locked_o     (cfg_done_o)
    );

    cfgtog_pin u_pin (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .evt_i   (evt),
        .level_o (img_sel_o),
        .oe_o    (img_sel_oe_o)
    );

    cfgtog_satcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .inc_i   (evt.take_fail),
        .count_o (fail_count_o)
    );

endmodule

// File: rtl/cfg_image_toggle_chk.sv
module cfg_image_toggle_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             crc_pass_i,
    input logic             crc_fail_i,
    input logic             img_sel_o,
    input logic             img_sel_oe_o,
    input logic             cfg_done_o,
    input logic [CNT_W-1:0] fail_count_o
);

    assert_undriven_clean_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !img_sel_oe_o |-> (fail_count_o == '0) && !img_sel_o);

    assert_first_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(img_sel_oe_o) |-> !img_sel_o && $past(crc_fail_i) && !$past(crc_pass_i));

    assert_toggle_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (img_sel_o != $past(img_sel_o)) |-> $past(img_sel_oe_o) && $past(crc_fail_i) && !$past(crc_pass_i));

    assert_locked_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(cfg_done_o) |-> cfg_done_o && $stable(img_sel_o) && $stable(img_sel_oe_o) && $stable(fail_count_o));

    assert_pass_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cfg_done_o) |-> $past(crc_pass_i) && $stable(fail_count_o) && $stable(img_sel_o));

    assert_count_no_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail_count_o >= $past(fail_count_o));

endmodule

bind cfg_image_toggle cfg_image_toggle_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .crc_pass_i   (crc_pass_i),
    .crc_fail_i   (crc_fail_i),
    .img_sel_o    (img_sel_o),
    .img_sel_oe_o (img_sel_oe_o),
    .cfg_done_o   (cfg_done_o),
    .fail_count_o (fail_count_o)
);

// File: tb/cfg_image_toggle_tb.sv
module cfg_image_toggle_tb;

    localparam int CNT_W = 4;
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    typedef struct {
        logic             oe;
        logic             lvl;
        logic             done;
        logic [CNT_W-1:0] cnt;
        string            tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, pass = 1'b0, fail = 1'b0;
    logic             sel, sel_oe, done;
    logic [CNT_W-1:0] cnt;

    always #2.5 clk = ~clk;

    cfg_image_toggle #(.CNT_W(CNT_W)) u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .load_start_i (start),
        .crc_pass_i   (pass),
        .crc_fail_i   (fail),
        .img_sel_o    (sel),
        .img_sel_oe_o (sel_oe),
        .cfg_done_o   (done),
        .fail_count_o (cnt)
    );

    int   n_run = 0, n_fail = 0;
    exp_t sb[$];

    // reference model state
    logic             m_open = 0, m_oe = 0, m_lvl = 0, m_done = 0;
    logic [CNT_W-1:0] m_cnt = '0;

    function automatic void compare(exp_t e);
        n_run++;
        if (sel_oe !== e.oe || sel !== e.lvl || done !== e.done || cnt !== e.cnt) begin
            n_fail++;
            $display("FAIL %s: got oe=%0d lvl=%0d done=%0d cnt=%0d, expected oe=%0d lvl=%0d done=%0d cnt=%0d",
                     e.tag, sel_oe, sel, done, cnt, e.oe, e.lvl, e.done, e.cnt);
        end
    endfunction

    // monitor: outputs settle after the edge; compare 1 ns later
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) compare(sb.pop_front());
    end

    task automatic step(input logic st, input logic ps, input logic fl, input string tag);
        exp_t e;
        @(negedge clk);
        start = st; pass = ps; fail = fl;
        if (!m_done) begin
            if (m_open && ps) begin
                m_done = 1; m_open = 0;
            end else if (m_open && fl) begin
                if (!m_oe) begin m_oe = 1; m_lvl = 0; end
                else m_lvl = ~m_lvl;
                if (m_cnt != CMAX) m_cnt = m_cnt + 1'b1;
                m_open = 0;
            end else if (st && !m_open) begin
                m_open = 1;
            end
        end
        e.oe = m_oe; e.lvl = m_lvl; e.done = m_done; e.cnt = m_cnt; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic do_reset(input string tag);
        exp_t e;
        @(negedge clk);
        start = 0; pass = 0; fail = 0;
        @(posedge clk); #2;
        rst_n = 1'b0;
        #0.5;
        m_open = 0; m_oe = 0; m_lvl = 0; m_done = 0; m_cnt = '0;
        e.oe = 0; e.lvl = 0; e.done = 0; e.cnt = '0; e.tag = tag;
        compare(e);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        exp_t e;
        repeat (3) @(negedge clk);
        // R1: reset values while held
        e.oe = 0; e.lvl = 0; e.done = 0; e.cnt = '0; e.tag = "R1 during reset";
        compare(e);
        rst_n = 1'b1;
        step(0, 0, 0, "R1 after release");
        // R8/R2: results with no open load ignored
        step(0, 0, 1, "R8 fail without load");
        step(0, 1, 0, "R8 pass without load");
        step(1, 0, 0, "R8 open load");
        step(1, 0, 0, "R8 start during load");
        step(0, 0, 0, "R2 still undriven");
        step(0, 0, 1, "R3 first fail drives low");
        step(0, 0, 1, "R8 fail after close");
        step(1, 0, 0, "R4 open retry");
        step(0, 0, 1, "R4 toggle high");
        step(1, 0, 0, "R4 open retry");
        step(1, 0, 1, "R4 toggle low, start same cycle");
        // R9: saturation
        for (int i = 0; i < 16; i++) begin
            step(1, 0, 0, "R9 open");
            step(0, 0, 1, "R9 count/saturate");
        end
        step(1, 0, 0, "R7 open");
        step(0, 1, 1, "R7 pass with fail");
        step(1, 0, 0, "R6 start after lock");
        step(0, 0, 1, "R6 fail after lock");
        step(0, 1, 1, "R6 both after lock");
        step(0, 0, 0, "R6 hold");
        do_reset("R10 reset after lock");
        step(0, 0, 0, "R10 after release");
        // R5: pass with no failure keeps line undriven
        step(1, 0, 0, "R5 open");
        step(0, 1, 0, "R5 pass clean");
        step(0, 0, 0, "R5 hold");
        do_reset("R10 reset again");
        step(1, 0, 0, "R5 open");
        step(0, 0, 1, "R3 first fail");
        step(1, 0, 0, "R5 open retry");
        step(0, 1, 0, "R5 pass frozen low driven");
        step(1, 0, 1, "R6 ignored");
        @(negedge clk);
        start = 0; pass = 0; fail = 0;
        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule